// File: doc/BRIEF.md
# Receive Frame Acceptance Filter

This block sits on the receive byte stream of an Ethernet MAC. It watches every frame as it arrives and decides whether the frame is kept or dropped. The frame arrives as a byte stream with a last-beat marker. The stream holds the received buffer contents, and its final two bytes are a status word appended by the receive logic upstream. That word carries the true frame length and an abort flag. So the length used for checking is not the number of bytes that arrived. The destination address is compared against a programmed station address while the first bytes stream past. The result of a separate multicast hash lookup arrives on its own input.

One clock after the last byte of a frame, the block pulses either accept or reject for a single cycle. A 2-bit reason code goes with each reject, and a saturating error counter records how many frames were rejected. The stream input never applies back-pressure. `s_ready` is low only while reset is applied and during the first clock after reset. From then on it stays high, so every beat with `s_valid` high is taken on the clock edge it is presented. The station address and the promiscuous and unicast-filter controls are sampled once per frame, on its first beat.

Top module: `rx_accept_filter`

## Requirements
- R1: `s_ready` is high from the second clock after reset and never falls afterwards. For every beat taken with `s_last` high, exactly one of `vd_accept` and `vd_reject` is high in the following cycle, for one cycle only. Neither is high at any other time.
- R2: When the raw beat count of a frame (all bytes, including the trailing two) lies between 2 and `BUF_BYTES` inclusive, the last two bytes form a status word. The earlier of the two bytes is bits 15:8. The checked length is bits 10:0 of the word, and bit 15 is the abort flag. Bits 14:11 are ignored.
- R3: When the raw beat count is 1 or exceeds `BUF_BYTES`, the checked length is the raw beat count and the abort flag is taken as clear.
- R4: A frame whose checked length is below 60 is rejected with reason 2'b01 (short).
- R5: A frame whose checked length is above 1518 is rejected with reason 2'b10 (long).
- R6: A frame whose abort flag is set is rejected with reason 2'b11 (abort). When several causes apply, the reason shown is picked in this order: abort, then short, then long, then address.
- R7: The destination is unicast when bit 0 of the first stream byte is 0. A unicast frame is rejected with reason 2'b00 (address) when the unicast filter is on, promiscuous mode is off, and the first six bytes do not all equal the station address. `sta_addr[47:40]` is compared with the first byte and `sta_addr[7:0]` with the sixth. A frame with fewer than six bytes never matches.
- R8: A unicast frame is accepted on the address check when promiscuous mode is on, or the unicast filter is off, or all six bytes match.
- R9: A group frame (bit 0 of the first byte set) skips the station comparison. It is rejected with reason 00 when promiscuous mode is off and `hash_hit` is low on its last beat. Otherwise it passes the address check.
- R10: `sta_addr`, `promisc_en` and `ucast_filt_en` are sampled on the first beat of a frame. Changing them later in the same frame has no effect on that frame's verdict.
- R11: `err_count` is 0 after reset. It rises by one on the same edge that raises `vd_reject`, saturates at its maximum, and is otherwise unchanged.
- R12: After reset, `vd_accept` and `vd_reject` are low and `vd_reason` is 2'b00. `vd_reason` holds the reason of the most recent reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream ready; high from the second clock after reset |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Marks the final byte of a frame |
| sta_addr | input | 8*ADDR_BYTES | Station address; bits 47:40 are compared with the first byte |
| promisc_en | input | 1 | Promiscuous mode |
| ucast_filt_en | input | 1 | Unicast address filter enable |
| hash_hit | input | 1 | Multicast hash lookup result, sampled on the last beat |
| vd_accept | output | 1 | One-cycle accept pulse |
| vd_reject | output | 1 | One-cycle reject pulse |
| vd_reason | output | 2 | Reject reason: 00 address, 01 short, 10 long, 11 abort |
| err_count | output | ERR_W | Saturating count of rejected frames |

## Verification
The hardest cases to reach from the ports sit at the edges of the raw beat count. Only there does the block switch from reading the status word to using the count itself. The bench drives frames of exactly `BUF_BYTES` and `BUF_BYTES`+1 bytes with the abort bit set, so the reason flips from abort to long. It also drives a 1519-byte frame whose status word claims a short, legal length, which shows the raw count is not used. One- and two-byte frames are driven as well. A full sweep of promiscuous mode, filter enable, group bit, hash hit and address match covers the address rules. Frames that change the configuration after their first beat show that the per-frame sampling holds.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  typedef enum logic [1:0] {
    RSN_ADDR  = 2'b00,
    RSN_SHORT = 2'b01,
    RSN_LONG  = 2'b10,
    RSN_ABORT = 2'b11
  } rsn_e;

  localparam int SW_W = 16;
endpackage

// File: rtl/rxf_addr_match.sv
module rxf_addr_match #(
  parameter int ADDR_BYTES = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    beat,
  input  logic                    first,
  input  logic [7:0]              data,
  input  logic [8*ADDR_BYTES-1:0] sta_sel,
  output logic                    grp_now,
  output logic                    full_match_now
);
  localparam int IDX_W = $clog2(ADDR_BYTES + 1);

  logic [7:0]       sta_b [ADDR_BYTES];
  logic [IDX_W-1:0] idx_q, idx_cur, idx_next;
  logic             eq_q, eq_prev, eq_next, grp_q, in_addr;
  logic [7:0]       sta_pick;

  // split the station address: most significant byte is first on the wire
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_split
    assign sta_b[g] = sta_sel[8*(ADDR_BYTES-1-g) +: 8];
  end

  assign idx_cur = first ? '0 : idx_q;
  assign eq_prev = first ? 1'b1 : eq_q;
  assign in_addr = idx_cur < IDX_W'(ADDR_BYTES);

  always_comb begin
    sta_pick = '0;
    for (int g = 0; g < ADDR_BYTES; g++)
      if (idx_cur == IDX_W'(g)) sta_pick = sta_b[g];
  end

  assign eq_next        = eq_prev && (!in_addr || (data == sta_pick));
  assign idx_next       = in_addr ? idx_cur + 1'b1 : idx_cur;
  assign grp_now        = first ? data[0] : grp_q;
  assign full_match_now = eq_next && (idx_next == IDX_W'(ADDR_BYTES));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= '0;
      eq_q  <= 1'b0;
      grp_q <= 1'b0;
    end else if (beat) begin
      idx_q <= idx_next;
      eq_q  <= eq_next;
      grp_q <= grp_now;
    end
  end

  // R7: the first beat of a frame restarts the address byte index
  assert_index_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && first) |=> (idx_q == IDX_W'(1)));

  // R7: the byte index never runs past the address field
  assert_index_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(ADDR_BYTES));
endmodule

// File: rtl/rxf_trailer.sv
module rxf_trailer import rxf_pkg::*; #(
  parameter int BUF_BYTES = 1536,
  parameter int LEN_BITS  = 11,
  parameter int ABORT_BIT = 15,
  parameter int CNT_W     = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            beat,
  input  logic            first,
  input  logic [7:0]      data,
  output logic [SW_W-1:0] len_now,
  output logic            abort_now
);
  localparam logic [SW_W-1:0]  LEN_MASK = SW_W'((1 << LEN_BITS) - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [CNT_W-1:0] cnt_q, cnt_cur, raw;
  logic [7:0]       hold_q;
  logic [SW_W-1:0]  sw;
  logic             use_sw;

  assign cnt_cur = first ? '0 : cnt_q;
  assign raw     = (cnt_cur == CNT_MAX) ? CNT_MAX : cnt_cur + 1'b1;
  assign sw      = {hold_q, data};
  assign use_sw  = (raw >= CNT_W'(2)) && (raw <= CNT_W'(BUF_BYTES));

  assign len_now   = use_sw ? (sw & LEN_MASK) : SW_W'(raw);
  assign abort_now = use_sw && sw[ABORT_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
    end else if (beat) begin
      cnt_q  <= raw;
      hold_q <= data;
    end
  end

  // R3: a taken beat always leaves a nonzero count behind
  assert_count_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> (cnt_q != '0));

  // R2: the raw count never drops while a frame continues
  assert_count_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !first) |=> (cnt_q >= $past(cnt_q)));
endmodule

// File: rtl/rxf_err_cnt.sv
module rxf_err_cnt #(
  parameter int ERR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [ERR_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (!rst_n)                 count <= '0;
    else if (inc && ~&count)    count <= count + 1'b1;
  end

  // R11: the counter never goes down
  assert_count_no_decrease_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count >= $past(count)));
endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter import rxf_pkg::*; #(
  parameter int ADDR_BYTES = 6,
  parameter int BUF_BYTES  = 1536,
  parameter int MIN_LEN    = 60,
  parameter int MAX_LEN    = 1518,
  parameter int LEN_BITS   = 11,
  parameter int ABORT_BIT  = 15,
  parameter int ERR_W      = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [7:0]              s_data,
  input  logic                    s_last,
  input  logic [8*ADDR_BYTES-1:0] sta_addr,
  input  logic                    promisc_en,
  input  logic                    ucast_filt_en,
  input  logic                    hash_hit,
  output logic                    vd_accept,
  output logic                    vd_reject,
  output logic [1:0]              vd_reason,
  output logic [ERR_W-1:0]        err_count
);
  localparam int STA_W  = 8*ADDR_BYTES;
  localparam int BUF_CW = $clog2(BUF_BYTES + 2);
  localparam int CNT_W  = ((BUF_CW > LEN_BITS) ? BUF_CW : LEN_BITS) + 1;

  logic             rdy_q, in_frame_q, beat, first, fin;
  logic [STA_W-1:0] sta_q, sta_sel;
  logic             prom_q, ucf_q, prom_sel, ucf_sel;
  logic             grp_now, full_match_now, abort_now;
  logic [SW_W-1:0]  len_now;
  logic             is_short, is_long, addr_bad, rej_now;
  rsn_e             rsn_now, rsn_q;

  assign s_ready = rdy_q;
  assign beat    = s_valid && rdy_q;
  assign first   = !in_frame_q;
  assign fin     = beat && s_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q      <= 1'b0;
      in_frame_q <= 1'b0;
    end else begin
      rdy_q <= 1'b1;
      if (beat) in_frame_q <= !s_last;
    end
  end

  // per-frame configuration snapshot, taken on the first beat
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_q  <= '0;
      prom_q <= 1'b0;
      ucf_q  <= 1'b0;
    end else if (beat && first) begin
      sta_q  <= sta_addr;
      prom_q <= promisc_en;
      ucf_q  <= ucast_filt_en;
    end
  end

  assign sta_sel  = first ? sta_addr      : sta_q;
  assign prom_sel = first ? promisc_en    : prom_q;
  assign ucf_sel  = first ? ucast_filt_en : ucf_q;

  rxf_addr_match #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .data(s_data),
    .sta_sel(sta_sel), .grp_now(grp_now), .full_match_now(full_match_now)
  );

  rxf_trailer #(.BUF_BYTES(BUF_BYTES), .LEN_BITS(LEN_BITS),
                .ABORT_BIT(ABORT_BIT), .CNT_W(CNT_W)) u_trl (
    .clk(clk), .rst_n(rst_n), .beat(beat), .first(first), .data(s_data),
    .len_now(len_now), .abort_now(abort_now)
  );

  assign is_short = len_now < SW_W'(MIN_LEN);
  assign is_long  = len_now > SW_W'(MAX_LEN);
  assign addr_bad = !prom_sel && (grp_now ? !hash_hit : (ucf_sel && !full_match_now));
  assign rej_now  = abort_now || is_short || is_long || addr_bad;

  always_comb begin
    if (abort_now)     rsn_now = RSN_ABORT;
    else if (is_short) rsn_now = RSN_SHORT;
    else if (is_long)  rsn_now = RSN_LONG;
    else               rsn_now = RSN_ADDR;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vd_accept <= 1'b0;
      vd_reject <= 1'b0;
      rsn_q     <= RSN_ADDR;
    end else begin
      vd_accept <= fin && !rej_now;
      vd_reject <= fin && rej_now;
      if (fin && rej_now) rsn_q <= rsn_now;
    end
  end

  assign vd_reason = rsn_q;

  rxf_err_cnt #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .inc(fin && rej_now), .count(err_count)
  );

  // R1: never both verdicts at once
  assert_single_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(vd_accept && vd_reject));

  // R1: a verdict appears only right after a last beat
  assert_verdict_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_accept || vd_reject) |-> $past(s_valid && s_ready && s_last));

  // R1: every last beat yields a verdict on the next cycle
  assert_last_yields_verdict_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last) |=> (vd_accept || vd_reject));

  // R1: once raised, ready stays high
  assert_ready_stays_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> s_ready);

  // R11: a reject advances the counter by one unless saturated
  assert_err_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (vd_reject && ($past(err_count) != {ERR_W{1'b1}})) |-> (err_count == $past(err_count) + 1'b1));

  // R11: without a reject the counter holds
  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_reject |-> $stable(err_count));

  // R12: the reason only changes alongside a reject pulse
  assert_reason_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !vd_reject |-> $stable(vd_reason));
endmodule

// File: tb/rx_accept_filter_test.sv
module rx_accept_filter_test;
  localparam int BUF = 1536;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        s_valid = 1'b0, s_last = 1'b0, s_ready;
  logic [7:0]  s_data = '0;
  logic [47:0] sta_addr = '0;
  logic        promisc_en = 1'b0, ucast_filt_en = 1'b0, hash_hit = 1'b0;
  logic        vd_accept, vd_reject;
  logic [1:0]  vd_reason;
  logic [15:0] err_count;

  int checks = 0, fails = 0, exp_err = 0;
  bit done = 0;

  localparam logic [47:0] ST = 48'h02_11_22_33_44_55;

  always #2 clk = ~clk;

  rx_accept_filter uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .sta_addr(sta_addr),
    .promisc_en(promisc_en), .ucast_filt_en(ucast_filt_en), .hash_hit(hash_hit),
    .vd_accept(vd_accept), .vd_reject(vd_reject), .vd_reason(vd_reason),
    .err_count(err_count)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] byte_at(int i, int n, logic [47:0] d, logic [15:0] sw);
    if (n >= 2 && i == n-2)      return sw[15:8];
    else if (n >= 2 && i == n-1) return sw[7:0];
    else if (i < 6)              return d[8*(5-i) +: 8];
    else                         return 8'(i) ^ 8'h5A;
  endfunction

  // send one frame, compute the expected verdict from the requirements and compare
  task automatic run_frame(input int n, input logic [47:0] d, input logic [15:0] sw,
                           input logic pr, input logic uf, input logic hh,
                           input bit midchg, input string tag);
    int  len;
    bit  ab, grp, match, abad, rej, sh, lg;
    int  rsn;
    sta_addr = ST; promisc_en = pr; ucast_filt_en = uf; hash_hit = hh;
    for (int i = 0; i < n; i++) begin
      s_valid = 1'b1;
      s_data  = byte_at(i, n, d, sw);
      s_last  = (i == n-1);
      @(posedge clk); #1;
      if (midchg && i == 0) begin
        sta_addr = ~ST; promisc_en = ~pr; ucast_filt_en = ~uf;
      end
    end
    s_valid = 1'b0; s_last = 1'b0;
    // model
    if (n >= 2 && n <= BUF) begin len = int'(sw[10:0]); ab = sw[15]; end
    else begin len = n; ab = 1'b0; end
    grp   = byte_at(0, n, d, sw) & 8'h01;
    match = (n >= 6);
    for (int i = 0; i < 6; i++)
      if (i < n && byte_at(i, n, d, sw) != ST[8*(5-i) +: 8]) match = 1'b0;
    abad = !pr && (grp ? !hh : (uf && !match));
    sh = len < 60; lg = len > 1518;
    rej = ab || sh || lg || abad;
    rsn = ab ? 3 : sh ? 1 : lg ? 2 : 0;
    if (rej) exp_err++;
    chk(vd_accept == !rej && vd_reject == rej, {tag, " verdict"}, {vd_accept, vd_reject}, {!rej, rej});
    if (rej) chk(vd_reason == 2'(rsn), {tag, " reason"}, vd_reason, rsn);
    chk(err_count == 16'(exp_err), "R11 err_count", err_count, exp_err);
    @(posedge clk); #1;
    chk(!vd_accept && !vd_reject, "R1 pulse width", {vd_accept, vd_reject}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!vd_accept && !vd_reject, "R12 reset verdict", {vd_accept, vd_reject}, 0);
    chk(vd_reason == 2'b00, "R12 reset reason", vd_reason, 0);
    chk(err_count == 0, "R12 reset err_count", err_count, 0);
    @(posedge clk); #1;
    chk(s_ready == 1'b1, "R1 ready after reset", s_ready, 1);

    // address sweep: promisc, filter, group, hash hit, match
    for (int k = 0; k < 32; k++) begin
      logic [47:0] d;
      bit pr = k[0], uf = k[1], gp = k[2], hh = k[3], mt = k[4];
      d = mt ? ST : (ST ^ 48'h1);
      if (gp) d = d | 48'h01_00_00_00_00_00;
      run_frame(64, d, 16'd62, pr, uf, hh, 0, gp ? "R9" : (mt || pr || !uf) ? "R8" : "R7");
    end
    // mismatch in the first byte only
    run_frame(64, ST ^ 48'h02_00_00_00_00_00, 16'd62, 0, 1, 0, 0, "R7 first byte");

    // length sweep around both bounds, with and without abort, junk in bits 14:11
    for (int ab = 0; ab < 2; ab++) begin
      for (int l = 50; l <= 70; l++)
        run_frame(64, ST, {1'(ab), 4'hA, 11'(l)}, 0, 1, 0, 0, ab ? "R6" : "R4");
      for (int l = 1508; l <= 1528; l++)
        run_frame(64, ST, {1'(ab), 4'hA, 11'(l)}, 0, 1, 0, 0, ab ? "R6" : "R5");
    end

    // raw count edges
    for (int n = 1; n <= 8; n++)
      run_frame(n, ST, 16'd100, 0, 0, 0, 0, n == 1 ? "R3" : "R2");
    run_frame(2, ST, 16'h8064, 0, 0, 0, 0, "R2 abort two bytes");
    run_frame(1519, ST, 16'd100, 0, 1, 0, 0, "R2 raw count ignored");
    run_frame(BUF,   ST, 16'h8064, 0, 1, 0, 0, "R6 at buffer size");
    run_frame(BUF+1, ST, 16'h8064, 0, 1, 0, 0, "R3 above buffer size");

    // configuration changed after the first beat
    run_frame(64, ST ^ 48'h1, 16'd62, 0, 1, 0, 1, "R10 mismatch kept");
    run_frame(64, ST,         16'd62, 0, 1, 0, 1, "R10 match kept");
    run_frame(64, ST ^ 48'h1, 16'd62, 1, 1, 0, 1, "R10 promisc kept");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule